// File: doc/BRIEF.md
# Packed Decimal Correction Unit

This block performs the decimal adjustment that follows a plain binary addition of two packed BCD words. After such an addition, each 4-bit digit that produced a carry (or, for the complementary form, each digit that did not) has to be moved back into decimal range by adding or removing six. The block receives the raw 64-bit register value, the per-bit carry vector that the earlier addition saved, and the separately held carry out of the top bit. From these it rebuilds one carry flag per digit, forms a word with a six in every digit selected for correction, and adds that word to the operand or subtracts it.

The saved carry vector keeps the carry into bit i at position i. The carry out of digit N therefore sits at bit 4N+4, and the carry out of the highest digit lives in the separate top-carry input. The block joins the two into one 65-bit value and shifts it right by four, so each digit's carry lands on bit 0 of that digit. Along with the corrected value it produces the per-bit carry vector and top carry of the correction operation itself, in the same storage convention, for the unit-condition logic downstream.

Inputs are taken on a valid strobe; the result, the new carry vector and the new top carry appear one clock later together with an output valid.

Top module: `bcd_fixup_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_result, out_carry_vec and out_carry_top are all cleared to zero after that edge.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high; when in_valid is low, out_result, out_carry_vec and out_carry_top keep their previous values.
- R3: The carry flag of digit N (N from 0 to 14, bits 4N+3..4N) is in_carry_vec bit 4N+4; the carry flag of the top digit (bits 63..60) is in_carry_top.
- R4: With in_add_mode = 1, every digit whose carry flag is 1 receives a correction of 6, and out_result = in_operand + correction word, modulo 2^64.
- R5: With in_add_mode = 0, every digit whose carry flag is 0 receives a correction of 6, and out_result = in_operand - correction word, modulo 2^64.
- R6: out_carry_vec bit i is the carry into bit i of the correction operation, which in subtract mode is carried out as in_operand + ~correction + 1; so bit 0 is 1 in subtract mode and 0 in add mode. out_carry_top is the carry out of bit 63 of that operation.
- R7: in_carry_vec bits 0 to 3 and every bit whose position is not a multiple of four have no effect on any output.
- R8: Correction of the top digit depends on in_carry_top alone: in add mode with in_operand zero, in_carry_top set and in_carry_vec zero, out_result is 0x6000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: sample the operand and carry state this cycle |
| in_add_mode | input | 1 | 1 = add the correction word, 0 = subtract it |
| in_operand | input | 64 | Binary sum to be corrected |
| in_carry_vec | input | 64 | Saved per-bit carry vector, carry into bit i at position i |
| in_carry_top | input | 1 | Saved carry out of bit 63 |
| out_valid | output | 1 | Result registers updated in the previous cycle |
| out_result | output | 64 | Decimal-corrected value |
| out_carry_vec | output | 64 | Per-bit carry vector of the correction operation |
| out_carry_top | output | 1 | Carry out of bit 63 of the correction operation |

## Verification
The bench goes after digit carry placement: a walking single carry through every digit position, in both modes, would expose a design that reads the flag one bit low (it would see bit 4N+3 and miss the carry) or that never looks at the separate top carry (the top digit would stay uncorrected, or always be corrected in subtract mode). Thousands of pseudo-random operands and carry vectors, with the bits that carry no meaning filled with noise, catch a design that lets such bits leak into the correction word. The per-bit carry vector of the correction is compared with a bit-serial ripple model, so a wrong carry-in for subtraction or a lost carry out of bit 63 shows up, and an idle cycle with changing inputs catches outputs that do not hold.

// File: rtl/bcd_fixup_pkg.sv
// Package: shared constants and the mode encoding for the decimal
// correction unit. Assumes 4-bit packed decimal digits.
package bcd_fixup_pkg;

    // Width of one packed decimal digit.
    localparam int unsigned DIGIT_W = 4;

    // Amount added to or removed from a digit that needs correction.
    localparam logic [DIGIT_W-1:0] FIX_AMOUNT = 4'd6;

    // Direction of the correction step.
    typedef enum logic {
        MODE_SUB = 1'b0,
        MODE_ADD = 1'b1
    } fix_mode_e;

endpackage

// File: rtl/bcd_carry_align.sv
// Module: bcd_carry_align
// Joins the saved carry vector with the separately held top carry and
// shifts the 65-bit value right by one digit, so the carry out of each
// digit ends up on bit 0 of that same digit.
// Assumes the saved vector holds the carry into bit i at position i.
module bcd_carry_align
    import bcd_fixup_pkg::*;
#(
    parameter int unsigned DIGITS = 16
) (
    input  logic [DIGITS*DIGIT_W-1:0] carry_vec,
    input  logic                      carry_top,
    output logic [DIGITS*DIGIT_W-1:0] aligned
);
    localparam int unsigned WORD_W = DIGITS * DIGIT_W;

    logic [WORD_W:0] joined;

    // Funnel: top carry becomes bit WORD_W of a single 65-bit value.
    assign joined = {carry_top, carry_vec};

    // Shift right by one digit; the vacated top bits fill with zero.
    assign aligned = WORD_W'(joined >> DIGIT_W);

endmodule

// File: rtl/bcd_corr_gen.sv
// Module: bcd_corr_gen
// Builds the correction word from the aligned carry word. In add mode the
// digits that carried are corrected, in subtract mode the ones that did not.
// Only bit 0 of each digit of the aligned word is meaningful; the rest is
// masked away. The times-six step uses two shifts and one add.
module bcd_corr_gen
    import bcd_fixup_pkg::*;
#(
    parameter int unsigned DIGITS = 16
) (
    input  logic [DIGITS*DIGIT_W-1:0] aligned,
    input  fix_mode_e                 mode,
    output logic [DIGITS*DIGIT_W-1:0] corr_word
);
    localparam int unsigned WORD_W = DIGITS * DIGIT_W;

    logic [WORD_W-1:0] digit_lsb_mask;
    logic [WORD_W-1:0] polarity;
    logic [WORD_W-1:0] unit_word;

    // One set bit at the bottom of every digit.
    for (genvar d = 0; d < DIGITS; d++) begin : g_mask
        assign digit_lsb_mask[d*DIGIT_W +: DIGIT_W] = DIGIT_W'(1);
    end

    // Subtract mode corrects digits without carry, so flip the flags.
    assign polarity = (mode == MODE_ADD) ? aligned : ~aligned;

    // Keep one selection bit per digit.
    assign unit_word = polarity & digit_lsb_mask;

    // Times six as (x*4)+(x*2); no digit overflows since each holds 0 or 1.
    assign corr_word = (unit_word << 2) + (unit_word << 1);

endmodule

// File: rtl/bcd_addsub.sv
// Module: bcd_addsub
// Adds the correction word to the operand, or subtracts it as
// operand + ~corr + 1, and reports the carry into every bit plus the carry
// out of the top bit, in the same convention as the saved carry state.
module bcd_addsub
    import bcd_fixup_pkg::*;
#(
    parameter int unsigned WORD_W = 64
) (
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] corr_word,
    input  fix_mode_e         mode,
    output logic [WORD_W-1:0] sum,
    output logic [WORD_W-1:0] carry_in_vec,
    output logic              carry_out
);
    logic [WORD_W-1:0] addend;
    logic              carry_seed;
    logic [WORD_W:0]   wide_sum;

    // Second operand and carry-in depend on the direction.
    assign addend     = (mode == MODE_ADD) ? corr_word : ~corr_word;
    assign carry_seed = (mode == MODE_SUB);

    // One wide adder gives both the sum and the carry out of the top bit.
    assign wide_sum = {1'b0, operand} + {1'b0, addend} + (WORD_W+1)'(carry_seed);

    // Split the wide sum into the word and the top carry.
    assign sum       = wide_sum[WORD_W-1:0];
    assign carry_out = wide_sum[WORD_W];

    // Carry into each bit recovered from the sum and the two inputs.
    assign carry_in_vec = operand ^ addend ^ sum;

endmodule

// File: rtl/bcd_fixup_unit.sv
// Module: bcd_fixup_unit (top)
// Decimal correction after a binary add of packed BCD words. Realigns the
// saved digit carries, forms the correction word of sixes, applies it in
// the selected direction and registers result and carry state for one
// cycle behind the input strobe. Synchronous active-low reset.
module bcd_fixup_unit
    import bcd_fixup_pkg::*;
#(
    parameter int unsigned DIGITS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_add_mode,
    input  logic [DIGITS*DIGIT_W-1:0] in_operand,
    input  logic [DIGITS*DIGIT_W-1:0] in_carry_vec,
    input  logic                      in_carry_top,
    output logic                      out_valid,
    output logic [DIGITS*DIGIT_W-1:0] out_result,
    output logic [DIGITS*DIGIT_W-1:0] out_carry_vec,
    output logic                      out_carry_top
);
    localparam int unsigned WORD_W = DIGITS * DIGIT_W;

    fix_mode_e         mode;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] corr_word;
    logic [WORD_W-1:0] next_result;
    logic [WORD_W-1:0] next_carry_vec;
    logic              next_carry_top;

    // Mode pin to its enumerated meaning.
    assign mode = in_add_mode ? MODE_ADD : MODE_SUB;

    bcd_carry_align #(.DIGITS(DIGITS)) u_align (
        .carry_vec (in_carry_vec),
        .carry_top (in_carry_top),
        .aligned   (aligned)
    );

    bcd_corr_gen #(.DIGITS(DIGITS)) u_corr (
        .aligned   (aligned),
        .mode      (mode),
        .corr_word (corr_word)
    );

    bcd_addsub #(.WORD_W(WORD_W)) u_arith (
        .operand      (in_operand),
        .corr_word    (corr_word),
        .mode         (mode),
        .sum          (next_result),
        .carry_in_vec (next_carry_vec),
        .carry_out    (next_carry_top)
    );

    // Valid follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result and carry state load on the strobe and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result    <= '0;
            out_carry_vec <= '0;
            out_carry_top <= 1'b0;
        end else if (in_valid) begin
            out_result    <= next_result;
            out_carry_vec <= next_carry_vec;
            out_carry_top <= next_carry_top;
        end
    end

endmodule

// File: rtl/bcd_fixup_unit_chk.sv
// Module: bcd_fixup_unit_chk
// Property checker bound to bcd_fixup_unit. Watches the ports and the
// internal correction word; drives nothing.
module bcd_fixup_unit_chk #(
    parameter int unsigned DIGITS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_add_mode,
    input logic                out_valid,
    input logic [DIGITS*4-1:0] out_result,
    input logic [DIGITS*4-1:0] out_carry_vec,
    input logic                out_carry_top,
    input logic [DIGITS*4-1:0] corr_word
);
    logic digits_ok;

    // Every digit of the correction word must be either 0 or 6.
    always_comb begin
        digits_ok = 1'b1;
        for (int d = 0; d < int'(DIGITS); d++) begin
            if (corr_word[d*4 +: 4] != 4'd0 && corr_word[d*4 +: 4] != 4'd6)
                digits_ok = 1'b0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0 && out_carry_vec == '0 && !out_carry_top));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry_vec)
                       && $stable(out_carry_top)));

    p_six_digits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> digits_ok);

    p_carry_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_carry_vec[0] == !$past(in_add_mode)));

endmodule

bind bcd_fixup_unit bcd_fixup_unit_chk #(.DIGITS(DIGITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_add_mode   (in_add_mode),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_carry_vec (out_carry_vec),
    .out_carry_top (out_carry_top),
    .corr_word     (corr_word)
);

// File: tb/bcd_fixup_unit_tb.sv
// Bench for bcd_fixup_unit: walking digit carries in both modes plus a
// long pseudo-random sweep, checked against an arithmetic digit model and
// a bit-serial ripple model of the carry vector.
module bcd_fixup_unit_tb;
    localparam int  DIGITS     = 16;
    localparam int  W          = DIGITS * 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MAX_CYCLES = 100000;
    localparam int  RAND_RUNS  = 3000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_add_mode;
    logic [W-1:0] in_operand;
    logic [W-1:0] in_carry_vec;
    logic         in_carry_top;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic [W-1:0] out_carry_vec;
    logic         out_carry_top;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    bcd_fixup_unit #(.DIGITS(DIGITS)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_add_mode   (in_add_mode),
        .in_operand    (in_operand),
        .in_carry_vec  (in_carry_vec),
        .in_carry_top  (in_carry_top),
        .out_valid     (out_valid),
        .out_result    (out_result),
        .out_carry_vec (out_carry_vec),
        .out_carry_top (out_carry_top)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= MAX_CYCLES) begin
            $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", MAX_CYCLES);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, failures + 1);
            $finish;
        end
    end

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Model: digit flags per R3, sixes per R4/R5, ripple carries per R6.
    task automatic model(input logic [W-1:0] op, input logic [W-1:0] cv, input logic top,
                         input logic add, output logic [W-1:0] res,
                         output logic [W-1:0] cvec, output logic ctop);
        logic [W-1:0] corr;
        logic [W-1:0] b;
        logic         c;
        logic         flag;
        corr = '0;
        for (int n = 0; n < DIGITS; n++) begin
            flag = (n == DIGITS-1) ? top : cv[4*n+4];
            if (flag == add) corr = corr + (W'(6) << (4*n));
        end
        res = add ? op + corr : op - corr;
        b = add ? corr : ~corr;
        c = !add;
        for (int i = 0; i < W; i++) begin
            cvec[i] = c;
            c = (op[i] & b[i]) | (op[i] & c) | (b[i] & c);
        end
        ctop = c;
    endtask

    // Drive one transaction at a falling edge, check it one cycle later.
    task automatic send(input string tag, input logic [W-1:0] op, input logic [W-1:0] cv,
                        input logic top, input logic add);
        logic [W-1:0] er;
        logic [W-1:0] ec;
        logic         et;
        model(op, cv, top, add, er, ec, et);
        in_valid = 1'b1; in_operand = op; in_carry_vec = cv;
        in_carry_top = top; in_add_mode = add;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 out_valid"}, W'(out_valid), W'(1));
        check({tag, add ? " R4 result" : " R5 result"}, out_result, er);
        check({tag, " R6 carry_vec"}, out_carry_vec, ec);
        check({tag, " R6 carry_top"}, W'(out_carry_top), W'(et));
    endtask

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] junk;
        rst_n = 1'b0; in_valid = 1'b1; in_add_mode = 1'b1;
        in_operand = '1; in_carry_vec = '1; in_carry_top = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held, even with a strobe.
        check("R1 out_valid", W'(out_valid), '0);
        check("R1 out_result", out_result, '0);
        check("R1 out_carry_vec", out_carry_vec, '0);
        check("R1 out_carry_top", W'(out_carry_top), '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R8: only the top carry set, add mode, zero operand.
        send("R8 top digit", '0, '0, 1'b1, 1'b1);
        check("R8 exact value", out_result, 64'h6000_0000_0000_0000);

        // R3: walking carry through every digit position, both modes.
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < DIGITS; n++) begin
                if (n == DIGITS-1) send("R3 walk top", 64'h0123_4567_8999_9999, '0, 1'b1, m[0]);
                else send("R3 walk", 64'h9999_8888_7777_6666, W'(1) << (4*n+4), 1'b0, m[0]);
                // Neighbouring bit one below must not count as a carry.
                if (n < DIGITS-1) send("R3 low neighbour", 64'h5555_5555_5555_5555, W'(1) << (4*n+3), 1'b0, m[0]);
            end
        end

        // R7: meaningless bits of the carry vector full of ones.
        junk = '0;
        for (int i = 0; i < W; i++) if (i % 4 != 0 || i == 0) junk[i] = 1'b1;
        send("R7 junk add", 64'h1234_5678_9ABC_DEF0, junk, 1'b0, 1'b1);
        check("R7 add unaffected", out_result, 64'h1234_5678_9ABC_DEF0);
        send("R7 junk sub", 64'h1234_5678_9ABC_DEF0, junk | 64'h1111_1111_1111_1110, 1'b1, 1'b0);
        check("R7 sub unaffected", out_result, 64'h1234_5678_9ABC_DEF0);

        // R4/R5/R6: pseudo-random sweep in both modes.
        for (int k = 0; k < RAND_RUNS; k++) begin
            send("R4 rand", next_rand(), next_rand(), rng[5], 1'b1);
            send("R5 rand", next_rand(), next_rand(), rng[9], 1'b0);
        end

        // R2: idle cycles with moving inputs leave the outputs unchanged.
        held = out_result;
        in_operand = ~in_operand; in_carry_vec = ~in_carry_vec; in_carry_top = ~in_carry_top;
        @(negedge clk);
        in_add_mode = ~in_add_mode;
        @(negedge clk);
        check("R2 idle valid low", W'(out_valid), '0);
        check("R2 idle result held", out_result, held);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, failures);
        $finish;
    end

endmodule